// File: doc/BRIEF.md
# Per-Queue Interrupt Source Selector

This block turns the status flags of a multi-queue FIFO manager into two interrupt lines. The queues are split into a lower half and an upper half. Each lower-half queue presents a 4-bit status nibble. A 3-bit source select for that queue picks one bit of the nibble and can optionally invert it. Upper-half queues have no select. Their trigger is always "queue is not nearly empty", derived from a per-queue nearly-empty flag.

A trigger that goes from false to true latches a pending bit for its queue. This happens whether or not interrupts are enabled for that queue. Software clears pending bits by writing ones to them. Each half has its own pending and enable register, and its interrupt line is raised while any of its queues is both pending and enabled.

A flat register port carries the configuration: a write strobe with address and data, and a combinational read path addressed separately.

Top module: `qirq_sel`

## Requirements
- R1: After reset every register (selects, both enables, both pending registers) reads zero and both `irq_lo` and `irq_hi` are low.
- R2: Select registers occupy offsets 0 to SEL_N-1 (0 to 3 by default), with eight queues per register. Queue q uses register q/8, where bits 4*(q%8)+2 down to 4*(q%8) hold its select. Bit 4*(q%8)+3 is reserved, ignores writes and reads 0.
- R3: For lower queue q, select bits 1:0 pick one bit of `stat_lo[4q+3:4q]`: 0 = empty, 1 = nearly empty, 2 = nearly full, 3 = full. Lower pending bit q sets at the clock edge where the chosen condition is sampled true after having been false on the previous edge. A reprogrammed select that makes the condition true counts the same way. Status bits that are not selected have no effect.
- R4: Select bit 2 inverts the chosen condition; for example, value 7 means "not full". With the inversion set, the pending bit sets when the chosen status bit falls.
- R5: Upper pending bit q sets at the edge where `hi_nempty[q]` is sampled low after having been high. Lower status and selects do not affect the upper half.
- R6: A pending bit sets even when its enable bit is clear. A half's interrupt line stays low while that half's enable register is zero.
- R7: The enable registers are at offset SEL_N (lower half) and SEL_N+1 (upper half), which are 4 and 5 by default. After each clock edge, a half's line is high exactly when some bit is both pending and enabled in the registers of that half.
- R8: The pending registers are at offset SEL_N+2 (lower half) and SEL_N+3 (upper half), which are 6 and 7 by default. Writing 1 to a bit clears it and writing 0 leaves it unchanged, so writing all ones clears the whole half.
- R9: When a new trigger and a clearing write hit the same pending bit at the same edge, the bit ends up set.
- R10: A condition that is already true when reset ends does not set its pending bit. A condition that stays true does not set the bit again after software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_lo | input | QPH*4 | Status nibble for each lower-half queue (empty, nearly empty, nearly full, full) |
| hi_nempty | input | QPH | Nearly-empty flag for each upper-half queue |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | DATA_W | Register read data, combinational from `rd_addr` |
| irq_lo | output | 1 | Interrupt line for the lower half |
| irq_hi | output | 1 | Interrupt line for the upper half |

## Verification
The bench builds the block with QPH = 32 and DATA_W = 32. With these values a pending or enable register spans the full data word, so an all-ones acknowledge reaches every queue of a half. The four select registers each hold eight queues, so all eight nibble positions and every select code can be reached. Directed steps cover each select code, inversion, the first edge after reset and a trigger that coincides with a clear. A seeded random phase then flips sparse status bits under mixed register writes against a bench model.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

   // Position of each flag inside a lower-half queue's status nibble
   typedef enum logic [1:0] {
      FLG_EMPTY  = 2'd0,
      FLG_LOW    = 2'd1,
      FLG_HIGH   = 2'd2,
      FLG_FULL   = 2'd3
   } qflag_e;

   // Stored source select of one lower-half queue
   typedef struct packed {
      logic   invert;
      qflag_e flag;
   } qsrc_t;

   localparam int unsigned SRC_W = $bits(qsrc_t);
   localparam int unsigned NIB_W = 4;

   // Trigger condition of one queue from its select and status nibble
   function automatic logic pick_cond(input qsrc_t s, input logic [NIB_W-1:0] nib);
      return nib[s.flag] ^ s.invert;
   endfunction

endpackage

// File: rtl/qirq_cond_mux.sv
module qirq_cond_mux
   import qirq_pkg::*;
#(
   parameter int unsigned QPH = 32
) (
   input  logic [QPH*SRC_W-1:0] sel_flat,
   input  logic [QPH*NIB_W-1:0] stat,
   output logic [QPH-1:0]       cond
);

   generate
      for (genvar q = 0; q < QPH; q++) begin : g_q
         qsrc_t sel_q;
         assign sel_q   = qsrc_t'(sel_flat[q*SRC_W +: SRC_W]);
         assign cond[q] = pick_cond(sel_q, stat[q*NIB_W +: NIB_W]);
      end
   endgenerate

endmodule

// File: rtl/qirq_pend_bank.sv
module qirq_pend_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cond,
   input  logic [W-1:0] clr,
   output logic [W-1:0] rise,
   output logic [W-1:0] pend
);

   logic [W-1:0] cond_q;
   logic         armed;

   // No edge is reported until the condition history holds a real sample
   assign rise = armed ? (cond & ~cond_q) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_q <= '0;
         armed  <= 1'b0;
         pend   <= '0;
      end else begin
         cond_q <= cond;
         armed  <= 1'b1;
         // a fresh trigger outranks a same-edge clear
         pend   <= (pend & ~clr) | rise;
      end
   end

endmodule

// File: rtl/qirq_regfile.sv
module qirq_regfile
   import qirq_pkg::*;
#(
   parameter int unsigned QPH    = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   input  logic [QPH-1:0]       pend_lo,
   input  logic [QPH-1:0]       pend_hi,
   output logic [QPH*SRC_W-1:0] sel_flat,
   output logic [QPH-1:0]       en_lo,
   output logic [QPH-1:0]       en_hi,
   output logic [QPH-1:0]       clr_lo,
   output logic [QPH-1:0]       clr_hi,
   output logic [DATA_W-1:0]    rd_data
);

   localparam int unsigned NPR   = DATA_W / NIB_W;
   localparam int unsigned SEL_N = (QPH + NPR - 1) / NPR;
   localparam logic [ADDR_W-1:0] A_EN_LO = ADDR_W'(SEL_N);
   localparam logic [ADDR_W-1:0] A_EN_HI = ADDR_W'(SEL_N + 1);
   localparam logic [ADDR_W-1:0] A_PD_LO = ADDR_W'(SEL_N + 2);
   localparam logic [ADDR_W-1:0] A_PD_HI = ADDR_W'(SEL_N + 3);

   generate
      if (DATA_W % NIB_W != 0) begin : g_bad_dw
         $error("DATA_W must be a multiple of the nibble width");
      end
      if (QPH > DATA_W) begin : g_bad_qph
         $error("QPH must fit in one data word");
      end
      if (QPH % NPR != 0) begin : g_bad_pack
         $error("QPH must fill whole select registers");
      end
      if (SEL_N + 4 > (1 << ADDR_W)) begin : g_bad_aw
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   qsrc_t                    sel_q [QPH];
   logic [SEL_N*DATA_W-1:0]  sel_pad;
   logic [QPH-1:0]           unused_rsvd;

   generate
      for (genvar q = 0; q < QPH; q++) begin : g_sel
         localparam int unsigned RIDX = q / NPR;
         localparam int unsigned BOFS = (q % NPR) * NIB_W;
         localparam logic [ADDR_W-1:0] RADDR = ADDR_W'(RIDX);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sel_q[q] <= '0;
            end else if (wr_en && wr_addr == RADDR) begin
               sel_q[q] <= qsrc_t'(wr_data[BOFS +: SRC_W]);
            end
         end

         assign sel_flat[q*SRC_W +: SRC_W]  = sel_q[q];
         assign sel_pad[q*NIB_W +: NIB_W]   = {1'b0, sel_q[q]};
         assign unused_rsvd[q]              = wr_data[BOFS + NIB_W - 1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_lo <= '0;
         en_hi <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_EN_LO) en_lo <= wr_data[QPH-1:0];
         if (wr_addr == A_EN_HI) en_hi <= wr_data[QPH-1:0];
      end
   end

   assign clr_lo = (wr_en && wr_addr == A_PD_LO) ? wr_data[QPH-1:0] : '0;
   assign clr_hi = (wr_en && wr_addr == A_PD_HI) ? wr_data[QPH-1:0] : '0;

   always_comb begin
      rd_data = '0;
      if (rd_addr < A_EN_LO) begin
         rd_data = sel_pad[int'(rd_addr)*DATA_W +: DATA_W];
      end else begin
         case (rd_addr)
            A_EN_LO: rd_data = DATA_W'(en_lo);
            A_EN_HI: rd_data = DATA_W'(en_hi);
            A_PD_LO: rd_data = DATA_W'(pend_lo);
            A_PD_HI: rd_data = DATA_W'(pend_hi);
            default: rd_data = '0;
         endcase
      end
   end

endmodule

// File: rtl/qirq_sel.sv
module qirq_sel
   import qirq_pkg::*;
#(
   parameter int unsigned QPH    = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [QPH*NIB_W-1:0] stat_lo,
   input  logic [QPH-1:0]       hi_nempty,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 irq_lo,
   output logic                 irq_hi
);

   localparam int unsigned HALVES = 2;

   logic [QPH*SRC_W-1:0] sel_flat;
   logic [QPH-1:0]       cond_lo, cond_hi;
   logic [QPH-1:0]       rise_lo, rise_hi;
   logic [QPH-1:0]       pend_lo, pend_hi;
   logic [QPH-1:0]       en_lo, en_hi;
   logic [QPH-1:0]       clr_lo, clr_hi;

   logic [QPH-1:0]       cond_h [HALVES];
   logic [QPH-1:0]       clr_h  [HALVES];
   logic [QPH-1:0]       rise_h [HALVES];
   logic [QPH-1:0]       pend_h [HALVES];
   logic [QPH-1:0]       en_h   [HALVES];
   logic [HALVES-1:0]    line_h;

   qirq_regfile #(
      .QPH    (QPH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .pend_lo  (pend_lo),
      .pend_hi  (pend_hi),
      .sel_flat (sel_flat),
      .en_lo    (en_lo),
      .en_hi    (en_hi),
      .clr_lo   (clr_lo),
      .clr_hi   (clr_hi),
      .rd_data  (rd_data)
   );

   qirq_cond_mux #(
      .QPH (QPH)
   ) u_mux (
      .sel_flat (sel_flat),
      .stat     (stat_lo),
      .cond     (cond_lo)
   );

   // upper half: fixed trigger, queue not nearly empty
   assign cond_hi = ~hi_nempty;

   assign cond_h[0] = cond_lo;
   assign cond_h[1] = cond_hi;
   assign clr_h[0]  = clr_lo;
   assign clr_h[1]  = clr_hi;
   assign en_h[0]   = en_lo;
   assign en_h[1]   = en_hi;

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         qirq_pend_bank #(
            .W (QPH)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (cond_h[h]),
            .clr   (clr_h[h]),
            .rise  (rise_h[h]),
            .pend  (pend_h[h])
         );
         assign line_h[h] = |(pend_h[h] & en_h[h]);
      end
   endgenerate

   assign rise_lo = rise_h[0];
   assign rise_hi = rise_h[1];
   assign pend_lo = pend_h[0];
   assign pend_hi = pend_h[1];
   assign irq_lo  = line_h[0];
   assign irq_hi  = line_h[1];

endmodule

// File: rtl/qirq_sel_chk.sv
module qirq_sel_chk #(
   parameter int unsigned QPH = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic [QPH-1:0] rise_lo,
   input logic [QPH-1:0] rise_hi,
   input logic [QPH-1:0] pend_lo,
   input logic [QPH-1:0] pend_hi,
   input logic [QPH-1:0] clr_lo,
   input logic [QPH-1:0] clr_hi,
   input logic [QPH-1:0] en_lo,
   input logic [QPH-1:0] en_hi,
   input logic           irq_lo,
   input logic           irq_hi
);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend_lo == '0 && pend_hi == '0 && en_lo == '0 && en_hi == '0 && !irq_lo && !irq_hi)); // R1

   AST_NO_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rise_lo == '0 && rise_hi == '0)); // R10

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_lo & ~$past(pend_lo) & ~$past(rise_lo)) == '0 &&
                (pend_hi & ~$past(pend_hi) & ~$past(rise_hi)) == '0)); // R3

   AST_CLEAR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr_lo) & ~$past(rise_lo) & pend_lo) == '0 &&
                ($past(clr_hi) & ~$past(rise_hi) & pend_hi) == '0)); // R8

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(rise_lo) & ~pend_lo) == '0 && ($past(rise_hi) & ~pend_hi) == '0)); // R9

   AST_LO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (en_lo == '0) |-> !irq_lo); // R6

   AST_HI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (en_hi == '0) |-> !irq_hi); // R6

   AST_HI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_hi == '0) |-> !irq_hi); // R7

endmodule

bind qirq_sel qirq_sel_chk #(.QPH(QPH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rise_lo (rise_lo),
   .rise_hi (rise_hi),
   .pend_lo (pend_lo),
   .pend_hi (pend_hi),
   .clr_lo  (clr_lo),
   .clr_hi  (clr_hi),
   .en_lo   (en_lo),
   .en_hi   (en_hi),
   .irq_lo  (irq_lo),
   .irq_hi  (irq_hi)
);

// File: tb/qirq_sel_test.sv
`timescale 1ns/1ps
module qirq_sel_test;

   localparam int QPH = 32;
   localparam int DW  = 32;
   localparam int AW  = 4;
   localparam logic [3:0] A_EN_LO = 4'd4, A_EN_HI = 4'd5, A_PD_LO = 4'd6, A_PD_HI = 4'd7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [QPH*4-1:0] stat_lo = '0;
   logic [QPH-1:0]  hi_nempty = '1;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [DW-1:0]   rd_data;
   logic            irq_lo, irq_hi;

   always #5 clk = ~clk;

   qirq_sel #(.QPH(QPH), .DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .stat_lo(stat_lo), .hi_nempty(hi_nempty),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   int n_chk = 0, n_fail = 0, cyc_cnt = 0;
   bit done = 0;

   // bench model
   logic [2:0]      m_sel [QPH];
   logic [QPH-1:0]  m_en_lo = '0, m_en_hi = '0, m_pd_lo = '0, m_pd_hi = '0;
   logic [QPH-1:0]  m_prev_lo = '0, m_prev_hi = '0;
   bit              m_armed = 0;
   logic [QPH*4-1:0] st = '0;
   logic [QPH-1:0]  nne = '1;

   function automatic logic mcond(int q, logic [QPH*4-1:0] s);
      logic [2:0] sl;
      sl = m_sel[q];
      return s[q*4 + int'(sl[1:0])] ^ sl[2];
   endfunction

   function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
      logic [DW-1:0] v;
      v = '0;
      if (a < 4) begin
         for (int k = 0; k < 8; k++) v[k*4 +: 4] = {1'b0, m_sel[int'(a)*8 + k]};
      end else if (a == A_EN_LO) v = m_en_lo;
      else if (a == A_EN_HI) v = m_en_hi;
      else if (a == A_PD_LO) v = m_pd_lo;
      else if (a == A_PD_HI) v = m_pd_hi;
      return v;
   endfunction

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt >= 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
         finish_up();
      end
   end

   // one clock cycle: drive at negedge, update model at the edge, check lines
   task automatic cyc(bit we, logic [3:0] wa, logic [31:0] wd);
      logic [QPH-1:0] c_lo, c_hi, r_lo, r_hi, k_lo, k_hi;
      stat_lo = st; hi_nempty = nne;
      wr_en = we; wr_addr = wa; wr_data = wd;
      @(posedge clk);
      for (int q = 0; q < QPH; q++) c_lo[q] = mcond(q, st);
      c_hi = ~nne;
      r_lo = m_armed ? (c_lo & ~m_prev_lo) : '0;
      r_hi = m_armed ? (c_hi & ~m_prev_hi) : '0;
      k_lo = (we && wa == A_PD_LO) ? wd : '0;
      k_hi = (we && wa == A_PD_HI) ? wd : '0;
      m_pd_lo = (m_pd_lo & ~k_lo) | r_lo;
      m_pd_hi = (m_pd_hi & ~k_hi) | r_hi;
      if (we) begin
         if (wa < 4) begin
            for (int k = 0; k < 8; k++) m_sel[int'(wa)*8 + k] = wd[k*4 +: 3];
         end
         if (wa == A_EN_LO) m_en_lo = wd;
         if (wa == A_EN_HI) m_en_hi = wd;
      end
      m_prev_lo = c_lo; m_prev_hi = c_hi; m_armed = 1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 irq_lo", {31'd0, irq_lo}, {31'd0, |(m_pd_lo & m_en_lo)});
      chk("R7 irq_hi", {31'd0, irq_hi}, {31'd0, |(m_pd_hi & m_en_hi)});
   endtask

   task automatic rd_is(logic [3:0] a, logic [31:0] exp, string tag);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 4'd0, 32'd0);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int q = 0; q < QPH; q++) m_sel[q] = '0;
      nne = 32'hFFFF_FFFE;  // upper queue 0 already not nearly empty
      hi_nempty = nne;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      for (int a = 0; a < 8; a++) rd_is(4'(a), 32'd0, "R1 reset read");
      chk("R1 irq_lo", {31'd0, irq_lo}, 32'd0);
      chk("R1 irq_hi", {31'd0, irq_hi}, 32'd0);
      // R10: condition true at reset end did not pend
      rd_is(A_PD_HI, 32'd0, "R10 no edge at reset");

      // R2: reserved nibble bit
      cyc(1, 4'd1, 32'hFFFF_FFFF);
      rd_is(4'd1, 32'h7777_7777, "R2 reserved bit reads 0");
      idle(1);
      cyc(1, 4'd1, 32'd0);
      cyc(1, A_PD_LO, 32'hFFFF_FFFF);
      rd_is(A_PD_LO, 32'd0, "R8 ack all");

      // R3: select picks one nibble bit
      cyc(1, 4'd0, 32'h0000_3210);
      rd_is(4'd0, 32'h0000_3210, "R2 select readback");
      st[10] = 1'b1;  // queue 2 nearly full (selected)
      st[6]  = 1'b1;  // queue 1 nearly full (not selected)
      cyc(0, 4'd0, 32'd0);
      rd_is(A_PD_LO, 32'h0000_0004, "R3 selected bit edge");

      // R4: inverted select
      cyc(1, 4'd0, 32'h0007_3210);
      idle(1);
      rd_is(A_PD_LO, 32'h0000_0014, "R4 reselect to not-full");
      cyc(1, A_PD_LO, 32'h0000_0014);
      rd_is(A_PD_LO, 32'd0, "R8 clear mask");
      st[19] = 1'b1; cyc(0, 4'd0, 32'd0);
      st[19] = 1'b0; cyc(0, 4'd0, 32'd0);
      rd_is(A_PD_LO, 32'h0000_0010, "R4 falling full sets");

      // R6 / R7: enable gating
      chk("R6 pending but disabled", {31'd0, irq_lo}, 32'd0);
      cyc(1, A_EN_LO, 32'h0000_0010);
      chk("R7 enabled pending", {31'd0, irq_lo}, 32'd1);
      cyc(1, A_EN_LO, 32'h0000_0020);
      chk("R7 other enable", {31'd0, irq_lo}, 32'd0);

      // R8: write-one-to-clear
      cyc(1, A_PD_LO, 32'd0);
      rd_is(A_PD_LO, 32'h0000_0010, "R8 zero write keeps");
      cyc(1, A_PD_LO, 32'h0000_0010);
      rd_is(A_PD_LO, 32'd0, "R8 one write clears");

      // R9: set beats clear
      st[10] = 1'b0; cyc(0, 4'd0, 32'd0);
      st[10] = 1'b1; cyc(1, A_PD_LO, 32'hFFFF_FFFF);
      rd_is(A_PD_LO, 32'h0000_0004, "R9 set wins");

      // R5: upper fixed trigger
      nne = 32'hFFFF_FFFF; st[0] = 1'b1; cyc(0, 4'd0, 32'd0);
      nne = 32'hFFFF_FFFE; cyc(0, 4'd0, 32'd0);
      rd_is(A_PD_HI, 32'h0000_0001, "R5 not nearly empty edge");
      cyc(1, A_EN_HI, 32'h0000_0001);
      chk("R7 irq_hi on", {31'd0, irq_hi}, 32'd1);
      cyc(1, A_PD_HI, 32'hFFFF_FFFF);
      chk("R8 irq_hi after ack", {31'd0, irq_hi}, 32'd0);
      idle(3);
      rd_is(A_PD_HI, 32'd0, "R10 steady condition no repend");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [3:0]  wa;
         logic [31:0] wd;
         bit          we;
         logic [3:0]  ra;
         for (int w = 0; w < 4; w++) st[w*32 +: 32] ^= $urandom & $urandom & $urandom;
         nne ^= $urandom & $urandom & $urandom;
         we = ($urandom_range(0, 3) == 0);
         wa = 4'($urandom_range(0, 7));
         wd = $urandom;
         if (wa >= A_PD_LO && $urandom_range(0, 1) == 0) wd = 32'hFFFF_FFFF;
         cyc(we, wa, wd);
         ra = 4'($urandom_range(0, 7));
         rd_addr = ra;
         #1;
         if (ra < 4) chk("R2 random select", rd_data, exp_rd(ra));
         else if (ra < 6) chk("R7 random enable", rd_data, exp_rd(ra));
         else chk("R3 random pending", rd_data, exp_rd(ra));
      end

      finish_up();
   end

endmodule